// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Two Compare Waveform Channels

This block is an up-counter that advances on count ticks taken from a shared system-clock divider. Two compare channels watch the count. Each channel raises a sticky match flag and drives a waveform pin according to a programmed action. The counter runs in one of three styles: free-running, restart-on-compare-A, or single-slope pulse-width modulation. In the PWM style the restart point is either the full count or compare A.

Software programs the block through a single write port, which has an address, a data word and a write strobe. The same port lets software load the count at any time and force a channel's pin action without a real match. Three flags cover overflow, match A and match B. Each flag has an enable that turns it into an interrupt request. An acknowledge input clears flags as an interrupt controller services them.

Top module: `wave_timer`

## Requirements
- R1: The control register is at address 0. Bits [1:0] select the mode and bits [4:2] select the clock. Clock select values 1 to 5 give one count tick every 1, 8, 64, 256 or 1024 system clocks. Ticks come from a free-running divider that is cleared by reset: a tick falls in the cycle where the divider's low 0, 3, 6, 8 or 10 bits are all ones. Values 0, 6 and 7 stop the count. After reset all registers, flags and pins are zero.
- R2: In mode 0 the count rises by one per tick and wraps from 0xFF to 0x00. The overflow flag (flag bit 0) is set on the tick that leaves 0xFF.
- R3: In mode 1 a tick taken while the count equals the active compare A value (address 3) returns the count to 0. The overflow flag is set only on a tick that leaves 0xFF.
- R4: In every mode, flag bit 1 is set on any tick whose count equals the active compare A value. Flag bit 2 does the same for compare B (address 4).
- R5: The action register is at address 1, with bits [1:0] for channel A and bits [3:2] for channel B. In modes 0 and 1 a match applies the channel's action: 0 holds the pin, 1 toggles it, 2 drives it low and 3 drives it high. The pin changes on the clock edge of the tick.
- R6: Modes 2 and 3 are fast PWM. The restart point (TOP) is 0xFF in mode 2 and the active compare A value in mode 3. A tick at TOP restarts the count at 0 and sets the overflow flag.
- R7: In fast PWM, on the restart tick action 2 drives the pin high and action 3 drives it low. On a match, action 2 drives the pin low and action 3 drives it high. When both fall on the same tick the restart value wins. Action 0 holds the pin.
- R8: In fast PWM, action 1 toggles pin A on its match only in mode 3. Pin B with action 1, and pin A with action 1 in mode 2, hold their level.
- R9: In modes 0 and 1, writing address 7 with bit 0 (channel A) or bit 1 (channel B) set applies that channel's action at the next clock. It sets no flag and leaves the count unchanged. A force on the same tick as a real match applies the action once. In PWM modes force writes have no effect.
- R10: Flags are sticky. Writing ones to address 5 clears the matching flag bits, and so do the irq_ack bits (same bit order). A hardware set in the same cycle as a clear wins.
- R11: Address 6 bits [2:0] enable the three flags. Each interrupt request equals its flag AND its enable.
- R12: In fast PWM, compare writes go into a buffer that is copied to the active value on the restart tick. In modes 0 and 1 a write becomes active at the next clock.
- R13: Address 2 loads the count at any time, and the load takes precedence over a tick's increment. The events of a coinciding tick still come from the count before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| irq_ack | input | 3 | Flag clear from the interrupt controller (bit 0 overflow, 1 match A, 2 match B) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Overflow flag |
| flag_ma | output | 1 | Compare A match flag |
| flag_mb | output | 1 | Compare B match flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_ma | output | 1 | Compare A interrupt request |
| irq_mb | output | 1 | Compare B interrupt request |

## Verification
A hardware flag set can land in the same cycle as a software or acknowledge clear. The bench provokes this by writing ones to the flag-clear register, and pulsing all acknowledge bits, on every cycle while a short restart period produces matches. It expects the flag to survive those cycles. A forced pin action can also coincide with a real compare match. The bench forces both channels on every cycle of a restart-on-compare run and expects a single toggle in the match cycle, not a cancelled pair. A behavioural model kept in the bench predicts both pins, all flags and all requests for every clock.

// File: rtl/wt_pkg.sv
package wt_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL   = 2'd0,
      MODE_CTC      = 2'd1,
      MODE_PWM_FULL = 2'd2,
      MODE_PWM_CMPA = 2'd3
   } wt_mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_SET    = 2'd3
   } wt_act_e;

   localparam logic [2:0] ADDR_CTRL  = 3'd0;
   localparam logic [2:0] ADDR_ACT   = 3'd1;
   localparam logic [2:0] ADDR_COUNT = 3'd2;
   localparam logic [2:0] ADDR_CMPA  = 3'd3;
   localparam logic [2:0] ADDR_CMPB  = 3'd4;
   localparam logic [2:0] ADDR_FLAGS = 3'd5;
   localparam logic [2:0] ADDR_IEN   = 3'd6;
   localparam logic [2:0] ADDR_FORCE = 3'd7;

   localparam int NCH    = 2;
   localparam int NFLAG  = 3;
   localparam int SEL_W  = 3;
   localparam int NTAP   = 5;

   function automatic logic mode_is_pwm(wt_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/wt_prescale.sv
module wt_prescale import wt_pkg::*; #(
   parameter int DIV_BITS = 10,
   parameter int TAP8     = 3,
   parameter int TAP64    = 6,
   parameter int TAP256   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   if (!(TAP8 > 0 && TAP8 < TAP64 && TAP64 < TAP256 && TAP256 < DIV_BITS)) begin : g_bad_taps
      $error("wt_prescale: divider taps must rise strictly below DIV_BITS");
   end

   function automatic int tap_bits(int idx);
      case (idx)
         0:       return 0;
         1:       return TAP8;
         2:       return TAP64;
         3:       return TAP256;
         default: return DIV_BITS;
      endcase
   endfunction

   logic [DIV_BITS-1:0] div_q;
   logic [NTAP-1:0]     hit;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      localparam int B = tap_bits(i);
      if (B == 0) begin : g_every
         assign hit[i] = 1'b1;
      end else begin : g_low_ones
         assign hit[i] = &div_q[B-1:0];
      end
   end

   always_comb begin
      case (sel)
         3'd1:    tick = hit[0];
         3'd2:    tick = hit[1];
         3'd3:    tick = hit[2];
         3'd4:    tick = hit[3];
         3'd5:    tick = hit[4];
         default: tick = 1'b0;
      endcase
   end

   // R1: with divide-by-8 held, two ticks are never adjacent
   p_div8_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd2 && tick) ##1 (sel == 3'd2) |-> !tick);

endmodule

// File: rtl/wt_counter.sv
module wt_counter import wt_pkg::*; #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  wt_mode_e      mode,
   input  logic [CW-1:0] top_a,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          wrap,
   output logic          ovf_evt
);

   logic [CW-1:0] top;
   logic          at_top;
   logic          at_max;

   always_comb begin
      if (mode == MODE_CTC || mode == MODE_PWM_CMPA) top = top_a;
      else                                            top = '1;
   end

   assign at_top  = (cnt == top);
   assign at_max  = (cnt == '1);
   assign wrap    = tick && at_top;
   assign ovf_evt = tick && (mode_is_pwm(mode) ? at_top : at_max);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (tick)  cnt <= at_top ? '0 : cnt + 1'b1;
   end

   // R3: a tick at compare A in CTC mode brings the count back to zero
   p_ctc_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CTC && tick && cnt == top_a && !load) |=> (cnt == '0));

   // R2: in normal mode every unloaded tick advances by exactly one
   p_normal_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_NORMAL && tick && !load) |=> (cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/wt_chan.sv
module wt_chan import wt_pkg::*; #(
   parameter int CW         = 8,
   parameter bit TOG_IN_PWM = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  wt_mode_e      mode,
   input  wt_act_e       act,
   input  logic          tick,
   input  logic [CW-1:0] cnt,
   input  logic          wrap,
   input  logic          cmp_we,
   input  logic [CW-1:0] cmp_wd,
   input  logic          force_i,
   output logic [CW-1:0] cmp_act,
   output logic          match,
   output logic          pin
);

   logic          pwm;
   logic          tog_ok;
   logic          pin_d;
   logic [CW-1:0] shadow_q;

   assign pwm   = mode_is_pwm(mode);
   assign match = tick && (cnt == cmp_act);

   if (TOG_IN_PWM) begin : g_tog
      assign tog_ok = (mode == MODE_PWM_CMPA);
   end else begin : g_no_tog
      assign tog_ok = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         cmp_act  <= '0;
      end else begin
         if (pwm && wrap) cmp_act <= shadow_q;
         if (cmp_we) begin
            shadow_q <= cmp_wd;
            if (!pwm) cmp_act <= cmp_wd;
         end
      end
   end

   always_comb begin
      pin_d = pin;
      if (pwm) begin
         if (wrap && act == ACT_CLEAR)     pin_d = 1'b1;
         else if (wrap && act == ACT_SET)  pin_d = 1'b0;
         else if (match) begin
            case (act)
               ACT_CLEAR:  pin_d = 1'b0;
               ACT_SET:    pin_d = 1'b1;
               ACT_TOGGLE: pin_d = tog_ok ? ~pin : pin;
               default:    pin_d = pin;
            endcase
         end
      end else if (match || force_i) begin
         case (act)
            ACT_TOGGLE: pin_d = ~pin;
            ACT_CLEAR:  pin_d = 1'b0;
            ACT_SET:    pin_d = 1'b1;
            default:    pin_d = pin;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= pin_d;
   end

   // R8: toggle action outside its permitted PWM case never moves the pin
   p_pwm_no_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && act == ACT_TOGGLE && !tog_ok) |=> $stable(pin));

   // R12: in PWM the active compare only changes on the restart tick
   p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm && !wrap) |=> $stable(cmp_act));

endmodule

// File: rtl/wave_timer.sv
module wave_timer import wt_pkg::*; #(
   parameter int CW       = 8,
   parameter int DIV_BITS = 10,
   parameter int TAP8     = 3,
   parameter int TAP64    = 6,
   parameter int TAP256   = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic [2:0]    irq_ack,
   output logic          wave_a,
   output logic          wave_b,
   output logic          flag_ovf,
   output logic          flag_ma,
   output logic          flag_mb,
   output logic          irq_ovf,
   output logic          irq_ma,
   output logic          irq_mb
);

   localparam int CS_LSB = 2;

   if (CW < CS_LSB + SEL_W) begin : g_bad_width
      $error("wave_timer: data width too narrow for the control register");
   end

   wt_mode_e         mode_q;
   logic [SEL_W-1:0] cs_q;
   wt_act_e          act_q [NCH];
   logic [NFLAG-1:0] ien_q;
   logic [NFLAG-1:0] flags_q;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;

   logic             tick;
   logic [CW-1:0]    cnt;
   logic             wrap;
   logic             ovf_evt;
   logic [CW-1:0]    cmp_act [NCH];
   logic [NCH-1:0]   match;
   logic [NCH-1:0]   pins;
   logic [NCH-1:0]   frc;
   logic             pwm;

   assign pwm = mode_is_pwm(mode_q);
   assign frc = (wr_en && wr_addr == ADDR_FORCE && !pwm) ? wr_data[NCH-1:0] : '0;

   wt_prescale #(
      .DIV_BITS(DIV_BITS), .TAP8(TAP8), .TAP64(TAP64), .TAP256(TAP256)
   ) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (cs_q),
      .tick (tick)
   );

   wt_counter #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .mode    (mode_q),
      .top_a   (cmp_act[0]),
      .load    (wr_en && wr_addr == ADDR_COUNT),
      .load_val(wr_data),
      .cnt     (cnt),
      .wrap    (wrap),
      .ovf_evt (ovf_evt)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      wt_chan #(.CW(CW), .TOG_IN_PWM(c == 0)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .mode   (mode_q),
         .act    (act_q[c]),
         .tick   (tick),
         .cnt    (cnt),
         .wrap   (wrap),
         .cmp_we (wr_en && wr_addr == (ADDR_CMPA + 3'(c))),
         .cmp_wd (wr_data),
         .force_i(frc[c]),
         .cmp_act(cmp_act[c]),
         .match  (match[c]),
         .pin    (pins[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_NORMAL;
         cs_q   <= '0;
         ien_q  <= '0;
         for (int c = 0; c < NCH; c++) act_q[c] <= ACT_NONE;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: begin
               mode_q <= wt_mode_e'(wr_data[1:0]);
               cs_q   <= wr_data[CS_LSB +: SEL_W];
            end
            ADDR_ACT:
               for (int c = 0; c < NCH; c++) act_q[c] <= wt_act_e'(wr_data[2*c +: 2]);
            ADDR_IEN:  ien_q <= wr_data[NFLAG-1:0];
            default: ;
         endcase
      end
   end

   assign set_v = {match[1], match[0], ovf_evt};
   assign clr_v = irq_ack | ((wr_en && wr_addr == ADDR_FLAGS) ? wr_data[NFLAG-1:0] : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_v) | set_v;
   end

   assign wave_a   = pins[0];
   assign wave_b   = pins[1];
   assign flag_ovf = flags_q[0];
   assign flag_ma  = flags_q[1];
   assign flag_mb  = flags_q[2];
   assign irq_ovf  = flags_q[0] & ien_q[0];
   assign irq_ma   = flags_q[1] & ien_q[1];
   assign irq_mb   = flags_q[2] & ien_q[2];

   // R2: an overflow event always shows up in the flag one clock later
   p_ovf_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag_ovf);

   // R9: a forced action leaves a clear compare A flag clear
   p_force_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frc[0] && !match[0] && !flags_q[1]) |=> !flags_q[1]);

   // R10: without a clear request a raised flag stays raised
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[0] && !clr_v[0]) |=> flags_q[0]);

endmodule

// File: tb/wave_timer_tb.sv
module wave_timer_tb;

   localparam int CLK_NS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] irq_ack = '0;
   logic wave_a, wave_b, flag_ovf, flag_ma, flag_mb, irq_ovf, irq_ma, irq_mb;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";

   always #(CLK_NS/2) clk = ~clk;

   wave_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_ack(irq_ack), .wave_a(wave_a), .wave_b(wave_b), .flag_ovf(flag_ovf),
      .flag_ma(flag_ma), .flag_mb(flag_mb), .irq_ovf(irq_ovf), .irq_ma(irq_ma),
      .irq_mb(irq_mb)
   );

   // behavioural reference state
   int         m_psc;
   logic [7:0] m_cnt, m_ca, m_cb, m_ba, m_bb;
   logic [1:0] m_mode, m_aa, m_ab;
   logic [2:0] m_cs, m_ien, m_flg;
   logic       m_wa, m_wb;

   task automatic model_reset();
      m_psc = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_ba = 0; m_bb = 0;
      m_mode = 0; m_aa = 0; m_ab = 0; m_cs = 0; m_ien = 0; m_flg = 0;
      m_wa = 0; m_wb = 0;
   endtask

   function automatic logic pin_next(logic cur, bit pwm, bit tog_ok, bit wrp,
                                     bit mt, bit frc, logic [1:0] act);
      if (pwm) begin
         if (wrp && act == 2) return 1'b1;
         if (wrp && act == 3) return 1'b0;
         if (mt) begin
            if (act == 2) return 1'b0;
            if (act == 3) return 1'b1;
            if (act == 1 && tog_ok) return ~cur;
         end
         return cur;
      end
      if (mt || frc) begin
         if (act == 1) return ~cur;
         if (act == 2) return 1'b0;
         if (act == 3) return 1'b1;
      end
      return cur;
   endfunction

   task automatic model_step(bit we, logic [2:0] a, logic [7:0] d, logic [2:0] ak);
      bit tk, pwm, atop, wrp, ovf, ma, mb, fa, fb;
      logic [7:0] top, n_ca, n_cb;
      logic [2:0] clr;
      case (m_cs)
         3'd1: tk = 1;
         3'd2: tk = (m_psc % 8) == 7;
         3'd3: tk = (m_psc % 64) == 63;
         3'd4: tk = (m_psc % 256) == 255;
         3'd5: tk = (m_psc % 1024) == 1023;
         default: tk = 0;
      endcase
      m_psc = (m_psc + 1) % 1024;
      pwm  = m_mode[1];
      top  = (m_mode == 1 || m_mode == 3) ? m_ca : 8'hFF;
      atop = (m_cnt == top);
      wrp  = tk && atop;
      ovf  = tk && (pwm ? atop : (m_cnt == 8'hFF));
      ma   = tk && (m_cnt == m_ca);
      mb   = tk && (m_cnt == m_cb);
      fa   = we && a == 7 && !pwm && d[0];
      fb   = we && a == 7 && !pwm && d[1];
      m_wa = pin_next(m_wa, pwm, m_mode == 3, wrp, ma, fa, m_aa);
      m_wb = pin_next(m_wb, pwm, 1'b0, wrp, mb, fb, m_ab);
      clr  = ak | ((we && a == 5) ? d[2:0] : 3'b000);
      m_flg = (m_flg & ~clr) | {mb, ma, ovf};
      if (we && a == 2)  m_cnt = d;
      else if (tk)       m_cnt = atop ? 8'h00 : m_cnt + 8'd1;
      n_ca = m_ca; n_cb = m_cb;
      if (pwm && wrp) begin n_ca = m_ba; n_cb = m_bb; end
      if (we && a == 3) begin m_ba = d; if (!pwm) n_ca = d; end
      if (we && a == 4) begin m_bb = d; if (!pwm) n_cb = d; end
      m_ca = n_ca; m_cb = n_cb;
      if (we && a == 0) begin m_mode = d[1:0]; m_cs = d[4:2]; end
      if (we && a == 1) begin m_aa = d[1:0]; m_ab = d[3:2]; end
      if (we && a == 6) m_ien = d[2:0];
   endtask

   task automatic check(logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs {irq,flags,wb,wa} actual %b expected %b at %0t",
                  cur_req, act, exp, $time);
      end
   endtask

   task automatic compare();
      check({irq_mb, irq_ma, irq_ovf, flag_mb, flag_ma, flag_ovf, wave_b, wave_a},
            {m_ien & m_flg, m_flg, m_wb, m_wa});
   endtask

   task automatic cyc(bit we, logic [2:0] a, logic [7:0] d, logic [2:0] ak);
      wr_en = we; wr_addr = a; wr_data = d; irq_ack = ak;
      @(posedge clk);
      model_step(we, a, d, ak);
      #1;
      compare();
      wr_en = 0; irq_ack = 0;
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      cyc(1, a, d, 3'b000);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 3'd0, 8'd0, 3'b000);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      summary();
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      cur_req = "R1 reset";
      compare();

      // R1: divide by 8 in normal mode, then stopped selects
      cur_req = "R1";
      wr(3'd0, 8'h08);
      idle(2200);
      wr(3'd2, 8'd250);
      wr(3'd0, 8'h18);
      idle(60);
      wr(3'd0, 8'h00);
      idle(20);
      wr(3'd5, 8'h07);

      // R2: normal mode every clock, with periodic flag clears
      cur_req = "R2";
      wr(3'd0, 8'h04);
      wr(3'd2, 8'd0);
      for (int k = 0; k < 3; k++) begin idle(200); wr(3'd5, 8'h01); end

      // R3 / R5: CTC with toggle and set actions
      cur_req = "R3";
      wr(3'd1, 8'd13);
      wr(3'd3, 8'd9);
      wr(3'd4, 8'd4);
      wr(3'd0, 8'h05);
      wr(3'd2, 8'd0);
      idle(60);
      cur_req = "R5";
      wr(3'd1, 8'd6);
      idle(40);
      wr(3'd1, 8'd11);
      idle(40);
      wr(3'd1, 8'd0);
      idle(20);
      // R4: compare B beyond TOP never matches, flags cleared first
      cur_req = "R4";
      wr(3'd5, 8'h07);
      wr(3'd4, 8'd30);
      idle(40);
      // R3: compare A below count runs through 0xFF to overflow
      cur_req = "R3";
      wr(3'd3, 8'd5);
      wr(3'd2, 8'd20);
      idle(300);

      // R6 / R7: fast PWM full range then compare-A TOP
      cur_req = "R7";
      wr(3'd1, 8'd14);
      wr(3'd0, 8'h06);
      wr(3'd3, 8'd100);
      wr(3'd4, 8'd200);
      idle(600);
      cur_req = "R6";
      wr(3'd0, 8'h07);
      wr(3'd3, 8'd30);
      wr(3'd4, 8'd10);
      idle(300);
      cur_req = "R7";
      wr(3'd4, 8'd30);
      idle(100);
      wr(3'd4, 8'd0);
      idle(100);

      // R8: toggle codes in both PWM modes
      cur_req = "R8";
      wr(3'd1, 8'd5);
      idle(150);
      wr(3'd0, 8'h06);
      idle(300);

      // R12: compare rewrite mid period in PWM
      cur_req = "R12";
      wr(3'd0, 8'h07);
      wr(3'd1, 8'd10);
      wr(3'd3, 8'd40);
      idle(100);
      wr(3'd4, 8'd5);
      idle(20);
      wr(3'd3, 8'd60);
      idle(120);

      // R9: forces every cycle in CTC (collides with matches), then in PWM
      cur_req = "R9";
      wr(3'd0, 8'h05);
      wr(3'd3, 8'd15);
      wr(3'd1, 8'd5);
      wr(3'd5, 8'h07);
      for (int k = 0; k < 40; k++) wr(3'd7, 8'h03);
      wr(3'd1, 8'd14);
      wr(3'd7, 8'h03);
      idle(3);
      wr(3'd0, 8'h07);
      for (int k = 0; k < 10; k++) wr(3'd7, 8'h03);

      // R10: clears colliding with hardware sets
      cur_req = "R10";
      wr(3'd0, 8'h05);
      wr(3'd3, 8'd3);
      wr(3'd4, 8'd1);
      for (int k = 0; k < 20; k++) wr(3'd5, 8'h07);
      for (int k = 0; k < 20; k++) cyc(0, 3'd0, 8'd0, 3'b111);
      idle(10);

      // R11: request enables
      cur_req = "R11";
      wr(3'd6, 8'h07);
      idle(30);
      wr(3'd6, 8'h02);
      for (int k = 0; k < 10; k++) cyc(0, 3'd0, 8'd0, 3'(k % 8));
      idle(20);

      // R13: count loads while ticking
      cur_req = "R13";
      wr(3'd3, 8'd50);
      for (int k = 0; k < 10; k++) begin wr(3'd2, 8'(k * 7)); idle(3); end
      wr(3'd2, 8'd49);
      idle(10);
      wr(3'd2, 8'd255);
      idle(5);

      summary();
      $finish;
   end

endmodule